// File: doc/BRIEF.md
# Integer Decode-and-Execute Unit

This block takes one 32-bit instruction word of a classic three-operand RISC instruction set at a time and runs it. It splits the word into its register-format or immediate-format fields, reads two source operands from a 32 x 32-bit register file, computes the result for one of six integer operations and writes that result into the register file on the clock edge that accepts the instruction. Register 0 is hardwired to zero.

The block handles register-register add, subtract and signed set-on-less-than, plus add-immediate, or-immediate and load-upper-immediate. Every other opcode or function code, including loads, stores, branches and jumps, is reported on a one-cycle illegal flag and leaves the register file untouched. A separate combinational debug port reads any register, so a host or a bench can observe the architectural state without issuing instructions.

Top module: `ixu_top`

## Requirements
- R1: After reset every register reads zero on the debug port and `illegal` is low.
- R2: A word with op = bits [31:26] = 0 and funct = bits [5:0] = 32 writes rs + rt (rs = bits [25:21], rt = bits [20:16]) into rd = bits [15:11], wrapping modulo 2^32 with no trap.
- R3: op 0 with funct 34 writes rs - rt into rd, wrapping modulo 2^32.
- R4: op 0 with funct 42 writes 1 into rd when rs < rt as two's-complement values, else 0.
- R5: op 8 writes rs plus the 16-bit immediate in bits [15:0], sign-extended, into rt, wrapping modulo 2^32.
- R6: op 13 writes rs OR the zero-extended 16-bit immediate into rt.
- R7: op 15 writes the immediate into bits [31:16] of rt and clears bits [15:0].
- R8: Register 0 always reads zero; any write aimed at it is dropped.
- R9: A valid word with any other op, or op 0 with any other funct, raises `illegal` for exactly the next cycle and changes no register.
- R10: While `instr_valid` is low the word on `instr_word` changes no register and `illegal` stays low.
- R11: The result is visible on the debug port right after the accepting clock edge, so an instruction issued in the next cycle reads the new value as a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |
| illegal | output | 1 | Previous-cycle word was not a handled instruction |

## Verification
Directed words build a full constant from an upper load followed by an or-immediate, drive add across the 32-bit wrap point, and compare negative against positive operands so a signed compare is told apart from an unsigned one. Further directed cases aim writes at register 0, present loads, jumps and an unknown funct, and leave a legal word on the bus with the strobe low, to separate a discarded write from a missing one. A long seeded random stream of mixed legal and illegal words issued back to back with heavy register reuse exposes forwarding and write-timing faults, and periodic sweeps of the debug port compare every register against a bench model.

// File: rtl/ixu_pkg.sv
package ixu_pkg;

   localparam int INSTR_W = 32;
   localparam int FLD_W   = 6;
   localparam int IDX_W   = 5;
   localparam int IMM_W   = 16;

   localparam logic [FLD_W-1:0] OPC_REG  = 6'd0;
   localparam logic [FLD_W-1:0] OPC_ADDI = 6'd8;
   localparam logic [FLD_W-1:0] OPC_ORI  = 6'd13;
   localparam logic [FLD_W-1:0] OPC_LUI  = 6'd15;

   localparam logic [FLD_W-1:0] FN_ADD = 6'd32;
   localparam logic [FLD_W-1:0] FN_SUB = 6'd34;
   localparam logic [FLD_W-1:0] FN_SLT = 6'd42;

   typedef enum logic [2:0] {
      K_ADD, K_SUB, K_SLT, K_ADDI, K_ORI, K_LUI, K_BAD
   } kind_e;

   typedef struct packed {
      kind_e             kind;
      logic [IDX_W-1:0]  src_a;
      logic [IDX_W-1:0]  src_b;
      logic [IDX_W-1:0]  dest;
      logic [IMM_W-1:0]  imm;
   } dec_t;

endpackage

// File: rtl/ixu_decode.sv
module ixu_decode
   import ixu_pkg::*;
(
   input  logic [INSTR_W-1:0] word,
   output dec_t               dec
);

   logic [FLD_W-1:0] opc;
   logic [FLD_W-1:0] fn;
   logic [IDX_W-1:0] f_rs, f_rt, f_rd;

   assign opc  = word[31:26];
   assign f_rs = word[25:21];
   assign f_rt = word[20:16];
   assign f_rd = word[15:11];
   assign fn   = word[5:0];

   always_comb begin
      dec.src_a = f_rs;
      dec.src_b = f_rt;
      dec.imm   = word[15:0];
      dec.dest  = f_rt;
      dec.kind  = K_BAD;
      unique case (opc)
         OPC_REG: begin
            dec.dest = f_rd;
            unique case (fn)
               FN_ADD:  dec.kind = K_ADD;
               FN_SUB:  dec.kind = K_SUB;
               FN_SLT:  dec.kind = K_SLT;
               default: dec.kind = K_BAD;
            endcase
         end
         OPC_ADDI: dec.kind = K_ADDI;
         OPC_ORI:  dec.kind = K_ORI;
         OPC_LUI:  dec.kind = K_LUI;
         default:  dec.kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/ixu_regfile.sv
module ixu_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] waddr,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [$clog2(NREG)-1:0] ra_a,
   output logic [DATA_W-1:0]       rd_a,
   input  logic [$clog2(NREG)-1:0] ra_b,
   output logic [DATA_W-1:0]       rd_b,
   input  logic [$clog2(NREG)-1:0] ra_dbg,
   output logic [DATA_W-1:0]       rd_dbg
);

   localparam int AW = $clog2(NREG);

   generate
      if (NREG < 2 || (1 << AW) != NREG)
         $error("ixu_regfile: NREG must be a power of two of at least 2");
      if (DATA_W < 1)
         $error("ixu_regfile: DATA_W must be positive");
   endgenerate

   logic [NREG-1:0][DATA_W-1:0] mem;
   logic                        wr_live;

   // entry 0 is never written, so it keeps its reset value of zero
   assign wr_live = we && (waddr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem <= '0;
      else if (wr_live) mem[waddr] <= wdata;
   end

   assign rd_a   = mem[ra_a];
   assign rd_b   = mem[ra_b];
   assign rd_dbg = mem[ra_dbg];

   // R11: an accepted write is present in storage after the edge
   p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_live |=> mem[$past(waddr)] == $past(wdata));

   // R9, R10 and R8: without a live write nothing in storage moves
   p_hold_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_live |=> $stable(mem));

   // R8: the zero entry never leaves zero
   p_zero_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem[0] == '0);

endmodule

// File: rtl/ixu_alu.sv
module ixu_alu
   import ixu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit SLT_BY_SUB = 1'b1
) (
   input  kind_e             kind,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] result
);

   localparam int MSB = DATA_W - 1;
   localparam int EXT = DATA_W - IMM_W;

   generate
      if (DATA_W <= IMM_W)
         $error("ixu_alu: DATA_W must exceed the immediate width");
   endgenerate

   logic [DATA_W-1:0] imm_s, imm_z, imm_hi;
   logic [DATA_W-1:0] sum_rr, diff_rr, sum_ri;
   logic              lt;

   assign imm_s  = {{EXT{imm[IMM_W-1]}}, imm};
   assign imm_z  = {{EXT{1'b0}}, imm};
   assign imm_hi = {imm, {EXT{1'b0}}};

   assign sum_rr  = opa + opb;
   assign diff_rr = opa - opb;
   assign sum_ri  = opa + imm_s;

   generate
      if (SLT_BY_SUB) begin : g_slt_sub
         // differing signs decide directly; equal signs cannot overflow
         assign lt = (opa[MSB] ^ opb[MSB]) ? opa[MSB] : diff_rr[MSB];
      end else begin : g_slt_cmp
         assign lt = $signed(opa) < $signed(opb);
      end
   endgenerate

   always_comb begin
      unique case (kind)
         K_ADD:   result = sum_rr;
         K_SUB:   result = diff_rr;
         K_SLT:   result = {{MSB{1'b0}}, lt};
         K_ADDI:  result = sum_ri;
         K_ORI:   result = opa | imm_z;
         K_LUI:   result = imm_hi;
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/ixu_top.sv
module ixu_top
   import ixu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NREG       = 32,
   parameter bit SLT_BY_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr_word,
   input  logic [4:0]        dbg_sel,
   output logic [DATA_W-1:0] dbg_data,
   output logic              illegal
);

   generate
      if (DATA_W != INSTR_W)
         $error("ixu_top: register width must equal the instruction width");
      if (NREG != (1 << IDX_W))
         $error("ixu_top: register count must match the 5-bit index fields");
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] src_a_val, src_b_val, alu_out;
   logic              rf_we;
   logic              bad_now;

   ixu_decode u_dec (
      .word (instr_word),
      .dec  (dec)
   );

   ixu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (rf_we),
      .waddr  (dec.dest),
      .wdata  (alu_out),
      .ra_a   (dec.src_a),
      .rd_a   (src_a_val),
      .ra_b   (dec.src_b),
      .rd_b   (src_b_val),
      .ra_dbg (dbg_sel),
      .rd_dbg (dbg_data)
   );

   ixu_alu #(.DATA_W(DATA_W), .SLT_BY_SUB(SLT_BY_SUB)) u_alu (
      .kind   (dec.kind),
      .opa    (src_a_val),
      .opb    (src_b_val),
      .imm    (dec.imm),
      .result (alu_out)
   );

   assign bad_now = instr_valid && (dec.kind == K_BAD);
   assign rf_we   = instr_valid && (dec.kind != K_BAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) illegal <= 1'b0;
      else        illegal <= bad_now;
   end

   // R9: the flag only ever answers a strobed word
   p_illegal_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $past(instr_valid));

   // R10: an idle cycle never produces a flag
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> !illegal);

   // R7: decode and datapath agree on the cleared lower half
   p_lui_low_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && dec.kind == K_LUI) |-> alu_out[15:0] == '0);

   // R4: a compare result is a single bit
   p_slt_boolean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && dec.kind == K_SLT) |-> alu_out[DATA_W-1:1] == '0);

endmodule

// File: tb/ixu_top_bench.sv
`timescale 1ns/1ps
module ixu_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [4:0]  dbg_sel = '0;
   logic [31:0] dbg_data;
   logic        illegal;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] m [32];
   logic        pend = 1'b0;
   logic        pend_bad = 1'b0;

   always #10 clk = ~clk;

   ixu_top u_ixu_top (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_word  (instr_word),
      .dbg_sel     (dbg_sel),
      .dbg_data    (dbg_data),
      .illegal     (illegal)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, rs[4:0], rt[4:0], imm};
   endfunction

   // bench model: updates m, returns 1 when the word is not handled
   function automatic logic model(input logic [31:0] w);
      logic [5:0]  op = w[31:26];
      logic [5:0]  fn = w[5:0];
      logic [31:0] a  = m[w[25:21]];
      logic [31:0] b  = m[w[20:16]];
      logic [15:0] im = w[15:0];
      logic [31:0] r  = '0;
      int          dst = w[20:16];
      logic        ok = 1'b1;
      case (op)
         6'd0: begin
            dst = w[15:11];
            case (fn)
               6'd32: r = a + b;
               6'd34: r = a - b;
               6'd42: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
               default: ok = 1'b0;
            endcase
         end
         6'd8:  r = a + {{16{im[15]}}, im};
         6'd13: r = a | {16'h0, im};
         6'd15: r = {im, 16'h0};
         default: ok = 1'b0;
      endcase
      if (ok && dst != 0) m[dst] = r;
      return !ok;
   endfunction

   task automatic close_pending();
      if (pend) chk("R9 flag", {31'd0, illegal}, {31'd0, pend_bad});
      pend = 1'b0;
   endtask

   task automatic issue(input logic [31:0] w);
      @(negedge clk);
      close_pending();
      instr_word  = w;
      instr_valid = 1'b1;
      pend_bad    = model(w);
      pend        = 1'b1;
   endtask

   task automatic settle();
      @(negedge clk);
      close_pending();
      instr_valid = 1'b0;
   endtask

   task automatic rd(input int idx, input logic [31:0] exp, input string req);
      @(negedge clk);
      dbg_sel = idx[4:0];
      #1;
      chk(req, dbg_data, exp);
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < 32; i++) rd(i, m[i], req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 32; i++) m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 illegal low", {31'd0, illegal}, 32'd0);
      sweep("R1 reset regs");

      // R7 then R6: full constant
      issue(enc_i(6'd15, 0, 8, 16'hF0F0));
      settle();
      rd(8, 32'hF0F0_0000, "R7 lui");
      issue(enc_i(6'd13, 8, 8, 16'hFF00));
      settle();
      rd(8, 32'hF0F0_FF00, "R6 ori");

      // R5 sign extension
      issue(enc_i(6'd8, 0, 9, 16'hFFFF));
      issue(enc_i(6'd8, 0, 10, 16'h0001));
      settle();
      rd(9, 32'hFFFF_FFFF, "R5 addi neg");
      // R2 wrap, R3 sub
      issue(enc_r(9, 10, 11, 6'd32));
      issue(enc_r(10, 9, 12, 6'd34));
      settle();
      rd(11, 32'h0, "R2 add wrap");
      rd(12, 32'h2, "R3 sub");

      // R4 signed compare
      issue(enc_r(9, 10, 13, 6'd42));
      issue(enc_r(10, 9, 14, 6'd42));
      issue(enc_r(10, 10, 15, 6'd42));
      settle();
      rd(13, 32'd1, "R4 neg<pos");
      rd(14, 32'd0, "R4 pos<neg");
      rd(15, 32'd0, "R4 equal");

      // R8 writes to register 0 dropped
      issue(enc_i(6'd8, 9, 0, 16'h1234));
      issue(enc_r(9, 9, 0, 6'd32));
      issue(enc_i(6'd15, 0, 0, 16'hABCD));
      settle();
      rd(0, 32'h0, "R8 zero reg");

      // R9 unhandled words
      issue(enc_i(6'd35, 0, 8, 16'h0004));
      issue(enc_r(9, 10, 8, 6'd0));
      issue({6'd2, 26'h0000010});
      issue(enc_i(6'd4, 9, 10, 16'h0002));
      settle();
      @(negedge clk);
      chk("R9 flag one cycle", {31'd0, illegal}, 32'd0);
      rd(8, 32'hF0F0_FF00, "R9 no write");
      sweep("R9 state");

      // R10 strobe low
      @(negedge clk);
      instr_word = enc_r(9, 9, 8, 6'd32);
      @(negedge clk);
      instr_word = enc_r(9, 9, 8, 6'd0);
      @(negedge clk);
      chk("R10 no flag", {31'd0, illegal}, 32'd0);
      rd(8, 32'hF0F0_FF00, "R10 no write");

      // R11 back-to-back dependency
      issue(enc_i(6'd8, 0, 16, 16'd5));
      issue(enc_r(16, 16, 17, 6'd32));
      issue(enc_r(17, 16, 18, 6'd34));
      settle();
      rd(17, 32'd10, "R11 forward add");
      rd(18, 32'd5, "R11 forward sub");

      // random stream
      for (int blk = 0; blk < 20; blk++) begin
         for (int n = 0; n < 100; n++) begin
            int k  = $urandom_range(0, 7);
            int rs = $urandom_range(0, 31);
            int rt = $urandom_range(0, 31);
            int rdd = $urandom_range(0, 31);
            logic [15:0] im = 16'($urandom);
            logic [5:0]  x  = 6'($urandom);
            logic [31:0] w;
            case (k)
               0: w = enc_r(rs, rt, rdd, 6'd32);
               1: w = enc_r(rs, rt, rdd, 6'd34);
               2: w = enc_r(rs, rt, rdd, 6'd42);
               3: w = enc_i(6'd8, rs, rt, im);
               4: w = enc_i(6'd13, rs, rt, im);
               5: w = enc_i(6'd15, rs, rt, im);
               6: begin
                  if (x == 6'd32 || x == 6'd34 || x == 6'd42) x = 6'd1;
                  w = enc_r(rs, rt, rdd, x);
               end
               default: begin
                  if (x == 6'd0 || x == 6'd8 || x == 6'd13 || x == 6'd15) x = 6'd43;
                  w = enc_i(x, rs, rt, im);
               end
            endcase
            issue(w);
         end
         settle();
         sweep("R2 R3 R4 R5 R6 R7 R11 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule